// File: doc/BRIEF.md
# D-Channel Contention Transmitter

This block sends frame data on the two D-channel bit slots of each frame of a shared time-division bus. Access to the shared D channel is settled by a free/busy indication that the physical layer device places on one bus bit, normally a bit of a neighbouring C/I field. The block samples that bit once per frame at a programmable position. A low value means the channel is free. A high value means a collision has been seen.

A frame is requested with a start pulse and a byte count. Bytes are read from an external frame buffer through an address/data pair. The block waits for a free indication before it sends its first bit, and it keeps watching the indication while it sends. If a collision is flagged while the block is still in the first buffers of the frame, it stops at once, rewinds, and resends from the first bit once a later sample reads free. A collision later in the frame ends the attempt with a failure status. Bit stuffing and CRC belong to a neighbouring block.

Top module: `dct_tx`

## Requirements
- R1: While reset is held, and directly after it, `d_oe`, `done`, `abort` and `retry_fail` are low and `rd_addr` is 0.
- R2: After `start`, no D bit is driven (`d_oe` stays low) until the indication bit, sampled at position `ind_pos` of a frame, reads 0 (free). A sample of 1 keeps the block waiting.
- R3: While sending, `d_oe` is high exactly in cycles where `d_strb` is high. `d_out` carries the frame bytes in ascending address order, each byte most significant bit first.
- R4: In the cycle after the strobe of the last bit of byte `frm_len-1`, `done` pulses for one cycle. The block then returns to idle and drives no more bits. At most one of `done`, `abort` and `retry_fail` is high in any cycle.
- R5: If an indication sample reads 1 while sending and the byte index in use is below RETRY_BYTES (default 2), then `abort` pulses in the next cycle with `rd_addr` back at 0. The block drives nothing until a later sample reads free, then resends the frame from byte 0, bit 7.
- R6: If an indication sample reads 1 while sending and the byte index in use is RETRY_BYTES or more, then `retry_fail` pulses in the next cycle. The block returns to idle and sends nothing more.
- R7: The indication is taken only at bit position `ind_pos`, counted from 0 at the `frame_sync` cycle. Values of `ind_bit` at all other positions have no effect.
- R8: A `start` pulse that arrives while a frame is being armed or sent is ignored. The frame in progress finishes with a single `done`, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | High in the cycle of bit position 0 of each frame |
| d_strb | input | 1 | High in each D-channel bit slot |
| ind_pos | input | POS_W | Bit position of the free/busy indication within the frame |
| ind_bit | input | 1 | Received bus bit; read at `ind_pos` (1 = collision/busy) |
| start | input | 1 | One-cycle request to send a frame |
| frm_len | input | LEN_W | Frame length in bytes (1 to MAX_BYTES), taken at `start` |
| rd_addr | output | AW | Frame buffer byte address |
| rd_data | input | BYTE_W | Frame buffer byte at `rd_addr` |
| d_out | output | 1 | D-channel data bit |
| d_oe | output | 1 | Drive enable for `d_out` |
| done | output | 1 | One-cycle pulse: frame sent completely |
| abort | output | 1 | One-cycle pulse: early collision, resend pending |
| retry_fail | output | 1 | One-cycle pulse: late collision, frame dropped |

## Verification
The assertions assume that the programmed indication position never coincides with a D-channel strobe. They also assume that `frm_len` is at least 1 and does not exceed MAX_BYTES. The bench keeps to this by placing the D slots at positions 8 and 9 and the indication at position 20 or 5. It drives `ind_bit` high at every position other than the programmed one, so a misplaced sample shows up at once. A sweep moves the collision frame across every D-slot pair of a four-byte frame, which covers both sides of the retry boundary.

// File: rtl/dct_pkg.sv
package dct_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_SEND = 2'd2
   } dct_state_e;
endpackage

// File: rtl/dct_slot_timer.sv
// Tracks the bit position within the frame and flags the indication slot.
module dct_slot_timer #(
   parameter int FRAME_BITS = 32,
   localparam int POS_W     = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_sync,
   input  logic [POS_W-1:0] ind_pos,
   output logic             ind_hit
);
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);

   logic [POS_W-1:0] pos_q, pos_now;
   logic             synced_q;

   always_comb begin
      if (frame_sync)            pos_now = '0;
      else if (pos_q == POS_LAST) pos_now = '0;
      else                        pos_now = pos_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= POS_LAST;
         synced_q <= 1'b0;
      end else begin
         pos_q    <= pos_now;
         synced_q <= synced_q | frame_sync;
      end
   end

   // no indication is trusted before the first frame alignment
   assign ind_hit = (synced_q | frame_sync) & (pos_now == ind_pos);
endmodule

// File: rtl/dct_shifter.sv
// Walks the frame buffer byte by byte and serialises the current byte.
module dct_shifter #(
   parameter int BYTE_W    = 8,
   parameter int MAX_BYTES = 16,
   parameter bit MSB_FIRST = 1'b1,
   localparam int AW       = $clog2(MAX_BYTES),
   localparam int LEN_W    = $clog2(MAX_BYTES + 1),
   localparam int BIT_W    = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              rewind,
   input  logic              step,
   input  logic [LEN_W-1:0]  frm_len,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [AW-1:0]     rd_addr,
   output logic              bit_out,
   output logic              last_bit
);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

   logic [AW-1:0]    addr_q;
   logic [BIT_W-1:0] bit_q;
   logic [LEN_W-1:0] len_q;
   logic             last_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         bit_q  <= '0;
         len_q  <= '0;
      end else if (load) begin
         addr_q <= '0;
         bit_q  <= '0;
         len_q  <= frm_len;
      end else if (rewind) begin
         addr_q <= '0;
         bit_q  <= '0;
      end else if (step) begin
         if (bit_q == BIT_LAST) begin
            bit_q  <= '0;
            addr_q <= addr_q + 1'b1;
         end else begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   assign last_byte = ((LEN_W'(addr_q) + 1'b1) == len_q);
   assign last_bit  = last_byte & (bit_q == BIT_LAST);
   assign rd_addr   = addr_q;

   generate
      if (MSB_FIRST) begin : g_msb
         logic [BIT_W-1:0] sel;
         assign sel     = BIT_LAST - bit_q;
         assign bit_out = rd_data[sel];
      end else begin : g_lsb
         assign bit_out = rd_data[bit_q];
      end
   endgenerate
endmodule

// File: rtl/dct_ctrl.sv
// Arbitration state machine: arm, send, abort/rewind or give up.
module dct_ctrl
   import dct_pkg::*;
#(
   parameter int AW          = 4,
   parameter int RETRY_BYTES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ind_hit,
   input  logic          ind_bit,
   input  logic          d_strb,
   input  logic          last_bit,
   input  logic [AW-1:0] byte_idx,
   output logic          load,
   output logic          rewind,
   output logic          step,
   output logic          sending,
   output logic          done,
   output logic          abort,
   output logic          retry_fail
);
   localparam logic [AW:0] RETRY_LIM = (AW + 1)'(RETRY_BYTES);

   dct_state_e st_q, st_d;
   logic       done_d, abort_d, fail_d;
   logic       collide, free, early;

   assign collide = ind_hit & ind_bit;
   assign free    = ind_hit & ~ind_bit;
   assign early   = ({1'b0, byte_idx} < RETRY_LIM);

   always_comb begin
      st_d    = st_q;
      load    = 1'b0;
      rewind  = 1'b0;
      step    = 1'b0;
      done_d  = 1'b0;
      abort_d = 1'b0;
      fail_d  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               load = 1'b1;
               st_d = ST_ARM;
            end
         end
         ST_ARM: begin
            if (free) st_d = ST_SEND;
         end
         ST_SEND: begin
            if (collide) begin
               rewind = 1'b1;
               if (early) begin
                  abort_d = 1'b1;
                  st_d    = ST_ARM;
               end else begin
                  fail_d = 1'b1;
                  st_d   = ST_IDLE;
               end
            end else if (d_strb) begin
               step = 1'b1;
               if (last_bit) begin
                  done_d = 1'b1;
                  rewind = 1'b1;
                  st_d   = ST_IDLE;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         done       <= 1'b0;
         abort      <= 1'b0;
         retry_fail <= 1'b0;
      end else begin
         st_q       <= st_d;
         done       <= done_d;
         abort      <= abort_d;
         retry_fail <= fail_d;
      end
   end

   assign sending = (st_q == ST_SEND);
endmodule

// File: rtl/dct_tx.sv
// D-channel contention transmitter top.
module dct_tx #(
   parameter int FRAME_BITS  = 32,
   parameter int BYTE_W      = 8,
   parameter int MAX_BYTES   = 16,
   parameter int RETRY_BYTES = 2,
   parameter bit MSB_FIRST   = 1'b1,
   localparam int POS_W      = $clog2(FRAME_BITS),
   localparam int AW         = $clog2(MAX_BYTES),
   localparam int LEN_W      = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_sync,
   input  logic              d_strb,
   input  logic [POS_W-1:0]  ind_pos,
   input  logic              ind_bit,
   input  logic              start,
   input  logic [LEN_W-1:0]  frm_len,
   output logic [AW-1:0]     rd_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              d_out,
   output logic              d_oe,
   output logic              done,
   output logic              abort,
   output logic              retry_fail
);
   initial begin
      if (FRAME_BITS < 4)
         $fatal(1, "dct_tx: FRAME_BITS must be at least 4");
      if (BYTE_W < 2)
         $fatal(1, "dct_tx: BYTE_W must be at least 2");
      if (MAX_BYTES < 2)
         $fatal(1, "dct_tx: MAX_BYTES must be at least 2");
      if (RETRY_BYTES < 1 || RETRY_BYTES > MAX_BYTES)
         $fatal(1, "dct_tx: RETRY_BYTES out of range");
   end

   logic ind_hit, load, rewind, step, sending, last_bit, bit_out;

   dct_slot_timer #(.FRAME_BITS(FRAME_BITS)) timer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_sync(frame_sync),
      .ind_pos   (ind_pos),
      .ind_hit   (ind_hit)
   );

   dct_shifter #(
      .BYTE_W   (BYTE_W),
      .MAX_BYTES(MAX_BYTES),
      .MSB_FIRST(MSB_FIRST)
   ) shift_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .rewind  (rewind),
      .step    (step),
      .frm_len (frm_len),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .bit_out (bit_out),
      .last_bit(last_bit)
   );

   dct_ctrl #(.AW(AW), .RETRY_BYTES(RETRY_BYTES)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ind_hit   (ind_hit),
      .ind_bit   (ind_bit),
      .d_strb    (d_strb),
      .last_bit  (last_bit),
      .byte_idx  (rd_addr),
      .load      (load),
      .rewind    (rewind),
      .step      (step),
      .sending   (sending),
      .done      (done),
      .abort     (abort),
      .retry_fail(retry_fail)
   );

   assign d_oe  = sending & d_strb;
   assign d_out = d_oe & bit_out;
endmodule

// File: rtl/dct_tx_chk.sv
// Property checker, attached to every dct_tx instance.
module dct_tx_chk #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          d_strb,
   input logic          d_oe,
   input logic          done,
   input logic          abort,
   input logic          retry_fail,
   input logic [AW-1:0] rd_addr,
   input logic          ind_hit
);
   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!d_oe && !done && !abort && !retry_fail && rd_addr == '0); // R1
      end
   end

   AST_SLOT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      !(d_strb && ind_hit)); // R7

   AST_OE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      d_oe |-> d_strb); // R3

   AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, abort, retry_fail})); // R4

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!d_oe && rd_addr == '0)); // R4

   AST_ABORT_REWOUND: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> (rd_addr == '0 && !d_oe)); // R5

   AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      retry_fail |-> (!d_oe && rd_addr == '0)); // R6

   AST_PULSE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !abort); // R5
endmodule

bind dct_tx dct_tx_chk #(.AW(AW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .d_strb    (d_strb),
   .d_oe      (d_oe),
   .done      (done),
   .abort     (abort),
   .retry_fail(retry_fail),
   .rd_addr   (rd_addr),
   .ind_hit   (ind_hit)
);

// File: tb/dct_tx_tb_top.sv
`timescale 1ns/1ps
module dct_tx_tb_top;
   localparam int FB    = 32;
   localparam int NLEN  = 4;
   localparam int NBITS = NLEN * 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_sync = 1'b0;
   logic       d_strb = 1'b0;
   logic [4:0] ind_pos = 5'd20;
   logic       ind_bit = 1'b1;
   logic       start = 1'b0;
   logic [4:0] frm_len = 5'(NLEN);
   logic [3:0] rd_addr;
   logic [7:0] rd_data;
   logic       d_out, d_oe, done, abort, retry_fail;

   logic [7:0] mem [16];
   int n_tests = 0, n_fail = 0;
   int bits_total = 0, idx = 0, n_done = 0, n_abort = 0, n_rfail = 0;
   bit mon_en = 1'b0;

   always #10 clk = ~clk;

   assign rd_data = mem[rd_addr];

   dct_tx dut_i (
      .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .d_strb(d_strb),
      .ind_pos(ind_pos), .ind_bit(ind_bit), .start(start), .frm_len(frm_len),
      .rd_addr(rd_addr), .rd_data(rd_data), .d_out(d_out), .d_oe(d_oe),
      .done(done), .abort(abort), .retry_fail(retry_fail)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: every driven bit is compared with the expected MSB-first stream
   always @(negedge clk) begin
      if (mon_en && rst_n) begin
         if (d_oe) begin
            int e;
            e = (idx < NBITS) ? int'(mem[idx / 8][7 - (idx % 8)]) : 2;
            chk(d_strb == 1'b1, "R3 oe-outside-strobe", int'(d_strb), 1);
            chk(int'(d_out) == e, "R3 bit value", int'(d_out), e);
            idx++;
            bits_total++;
         end
         if (abort)      begin n_abort++; idx = 0; end
         if (done)       n_done++;
         if (retry_fail) n_rfail++;
      end
   end

   task automatic frame(input bit st, input bit busy);
      for (int p = 0; p < FB; p++) begin
         frame_sync = (p == 0);
         d_strb     = (p == 8) || (p == 9);
         ind_bit    = (p == int'(ind_pos)) ? busy : 1'b1;
         start      = st && (p == 0);
         @(posedge clk);
         #1;
      end
      frame_sync = 1'b0;
      d_strb     = 1'b0;
      start      = 1'b0;
   endtask

   task automatic prep(input int seed);
      for (int i = 0; i < 16; i++) mem[i] = 8'((seed * 37 + i * 91 + 5) & 255);
      bits_total = 0; idx = 0; n_done = 0; n_abort = 0; n_rfail = 0;
   endtask

   initial begin
      mon_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(d_oe == 0 && done == 0 && abort == 0 && retry_fail == 0, "R1 reset outputs",
          int'({d_oe, done, abort, retry_fail}), 0);
      chk(rd_addr == 0, "R1 reset address", int'(rd_addr), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(d_oe == 0 && done == 0 && rd_addr == 0, "R1 after reset",
          int'({d_oe, done}), 0);
      frame(1'b0, 1'b0);
      mon_en = 1'b1;

      // R2: busy indication holds the frame back
      prep(1);
      frame(1'b1, 1'b1);
      frame(1'b0, 1'b1);
      frame(1'b0, 1'b1);
      chk(bits_total == 0, "R2 no bits while busy", bits_total, 0);
      frame(1'b0, 1'b0);
      chk(bits_total == 0, "R2 first free sample after D slots", bits_total, 0);
      for (int f = 0; f < 18; f++) frame(1'b0, 1'b0);
      chk(bits_total == NBITS, "R3 full frame sent", bits_total, NBITS);
      chk(n_done == 1, "R4 single done", n_done, 1);
      chk(n_abort == 0 && n_rfail == 0, "R4 no error status", n_abort + n_rfail, 0);

      // R5/R6 sweep: collision after 2*m bits
      for (int m = 1; m < 16; m++) begin
         prep(m + 10);
         frame(1'b1, 1'b0);
         for (int f = 1; f <= m; f++) frame(1'b0, f == m);
         chk(bits_total == 2 * m, "R3 bits before collision", bits_total, 2 * m);
         if (2 * m < 16) begin
            chk(n_abort == 1 && n_rfail == 0, "R5 early collision aborts", n_abort, 1);
            chk(rd_addr == 0, "R5 rewound address", int'(rd_addr), 0);
            for (int f = 0; f < 19; f++) frame(1'b0, 1'b0);
            chk(n_done == 1, "R5 resend completes", n_done, 1);
            chk(idx == NBITS, "R5 resend from first bit", idx, NBITS);
            chk(bits_total == 2 * m + NBITS, "R5 total bits", bits_total, 2 * m + NBITS);
         end else begin
            chk(n_rfail == 1 && n_abort == 0, "R6 late collision fails", n_rfail, 1);
            for (int f = 0; f < 4; f++) frame(1'b0, 1'b0);
            chk(bits_total == 2 * m, "R6 no resend", bits_total, 2 * m);
            chk(n_done == 0, "R6 no done", n_done, 0);
         end
      end

      // R7 moved indication position, R8 stray start while sending
      ind_pos = 5'd5;
      prep(3);
      frame(1'b1, 1'b0);
      chk(bits_total == 2, "R7 sample at position 5 precedes D slots", bits_total, 2);
      frame(1'b0, 1'b0);
      frame(1'b1, 1'b0);
      for (int f = 0; f < 18; f++) frame(1'b0, 1'b0);
      chk(n_done == 1, "R8 stray start ignored", n_done, 1);
      chk(bits_total == NBITS, "R8 single frame sent", bits_total, NBITS);
      chk(n_abort == 0 && n_rfail == 0, "R7 off-position highs ignored", n_abort + n_rfail, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule